// File: doc/BRIEF.md
# Command Stream Front-End Parser

This block takes a stream of 32-bit command words and decodes them into actions. Each command starts with a header word. The opcode sits in the five top bits, and the other 27 bits carry fields that depend on the opcode. Argument words may follow the header.

The parser acts on each command in one of these ways:

- State loads become register writes, given as (word address, data) pairs. When the header asks for it, each payload is first converted from signed 16.16 fixed point to single-precision float.
- Jump commands (link, call and return) become redirect requests. Each request carries a kind, an address and a byte length.
- Draw, 2D start, stall and chip-select commands become an opaque event stream. The stream carries the header and then the argument words, with first and last markers.
- Wait holds the parser for a programmed number of cycles.
- End parks the parser until reset.
- An illegal opcode parks it in a sticky error state until reset.

Every command, counting its header, spans an even number of words. When the count is odd, the parser drops the trailing pad word without looking at it.

The input and the three output streams use valid/ready. A word moves when valid and ready are both high at a rising clock edge. An output that shows valid keeps its payload stable until it is taken. The parser takes a word only when the output that word feeds is empty or is being drained in the same cycle. Back-pressure on any output therefore reaches the input in the same cycle and loses no word. While the parser is in the header stage it needs both the event and the redirect outputs free before it takes a header.

Top module: `cmdp_top`

## Requirements
- R1: A header whose opcode field [31:27] is none of 1 (state), 2 (end), 3 (nop), 4 (2D start), 5 (draw), 6 (indexed draw), 7 (wait), 8 (link), 9 (stall), 10 (call), 11 (return) or 13 (chip select) sets `err`. The parser then holds `in_ready` low and takes no further word until reset.
- R2: A state-load header carries a base word address in [15:0] and a word count in [25:16]. The count data words that follow are written, one per `wr` beat, to base, base+1, and so on. Each word is written unchanged when bit 26 is clear.
- R3: When bit 26 of a state-load header is set, each data word is read as signed 16.16 and written as IEEE-754 single precision, with the mantissa truncated toward zero. Zero gives +0.0. A negative value gives the float of its magnitude with the sign bit set.
- R4: When header plus argument words total an odd count, the next input word is consumed and produces no output and no error, whatever its value.
- R5: A wait header carries a cycle count in [15:0]. After its pad word is taken, `in_ready` stays low for exactly that many cycles; a count of zero adds no stall.
- R6: Link and call headers carry a byte length in [15:0]. The next word is taken as the target address, and one redirect beat is issued with kind 1 for link or 2 for call. Return issues one redirect beat with kind 3 and zero address and length.
- R7: Event commands emit the header as a beat with `ev_first`=1, then their argument words. The argument counts are: draw 3, indexed draw 4, stall 1, chip select 0, and 2D start 1 + 2×[15:8]. `ev_op` carries the opcode on every beat, and `ev_last` marks the final beat.
- R8: An end header raises `ended`; no further word is taken until reset.
- R9: An output beat that is valid and not ready keeps valid and payload stable. Under any ready pattern, every expected beat is delivered once and in order.
- R10: After reset, `in_ready` is high and all output valids, `ended` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser takes the word this cycle |
| wr_valid | output | 1 | Register write beat present |
| wr_ready | input | 1 | Write sink accepts |
| wr_addr | output | 16 | Write word address |
| wr_data | output | 32 | Write data (converted if requested) |
| ev_valid | output | 1 | Event beat present |
| ev_ready | input | 1 | Event sink accepts |
| ev_op | output | 5 | Opcode of the event command |
| ev_data | output | 32 | Header or argument word |
| ev_first | output | 1 | Beat is the header |
| ev_last | output | 1 | Final beat of the event |
| rd_valid | output | 1 | Redirect request present |
| rd_ready | input | 1 | Redirect sink accepts |
| rd_kind | output | 2 | 1 link, 2 call, 3 return |
| rd_addr | output | 32 | Target address |
| rd_bytes | output | 16 | Target length in bytes |
| ended | output | 1 | End command seen |
| err | output | 1 | Illegal opcode seen |

## Verification
The assertions assume that the sinks follow the valid/ready rule, and they place no constraint on `in_valid` or `in_data`. Their stability checks need only that reset is held for at least one clock. The random stimulus builds only well-formed commands, so an odd or random pad word can reach the header decoder only if the skipping logic is wrong. Illegal opcodes and end commands are sent only in directed runs that reset afterwards. The sink readies follow a fixed percentage in each run, from always ready to mostly stalled.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  localparam int WORD_W   = 32;
  localparam int OP_W     = 5;
  localparam int OP_LSB   = 27;
  localparam int ADDR_W   = 16;
  localparam int CNT_W    = 16;
  localparam int SCNT_W   = 10;
  localparam int SCNT_LSB = 16;
  localparam int FIXP_BIT = 26;
  localparam int RECT_LSB = 8;
  localparam int RECT_W   = 8;
  localparam int KIND_W   = 2;
  localparam int FRAC_W   = 16;
  localparam int MANT_W   = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;

  typedef enum logic [OP_W-1:0] {
    OP_STATE   = 5'd1,
    OP_END     = 5'd2,
    OP_NOP     = 5'd3,
    OP_DRAW2D  = 5'd4,
    OP_DRAW    = 5'd5,
    OP_DRAWIDX = 5'd6,
    OP_WAIT    = 5'd7,
    OP_LINK    = 5'd8,
    OP_STALL   = 5'd9,
    OP_CALL    = 5'd10,
    OP_RET     = 5'd11,
    OP_CHIPSEL = 5'd13
  } opcode_e;

  typedef enum logic [KIND_W-1:0] {
    RD_NONE = 2'd0,
    RD_LINK = 2'd1,
    RD_CALL = 2'd2,
    RD_RET  = 2'd3
  } redir_e;

  typedef enum logic [2:0] {
    ST_HDR, ST_DATA, ST_EVARG, ST_JARG, ST_PAD, ST_WAIT, ST_END, ST_ERR
  } pstate_e;

  typedef struct packed {
    logic             legal;
    logic [OP_W-1:0]  op;
    logic [CNT_W-1:0] nargs;
    logic             pad;
    logic             is_state;
    logic             is_end;
    logic             is_wait;
    logic             is_jump;
    logic             is_ret;
    logic             is_event;
  } hdr_info_t;

endpackage

// File: rtl/cmdp_hdr_dec.sv
module cmdp_hdr_dec
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] hdr,
  output hdr_info_t         info
);

  logic [OP_W-1:0] op;
  assign op = hdr[OP_LSB +: OP_W];

  always_comb begin
    info       = '0;
    info.op    = op;
    info.legal = 1'b1;
    case (op)
      OP_STATE: begin
        info.is_state = 1'b1;
        info.nargs    = CNT_W'(hdr[SCNT_LSB +: SCNT_W]);
      end
      OP_END:   info.is_end  = 1'b1;
      OP_NOP:   info.nargs   = '0;
      OP_WAIT:  info.is_wait = 1'b1;
      OP_LINK, OP_CALL: begin
        info.is_jump = 1'b1;
        info.nargs   = CNT_W'(1);
      end
      OP_RET:   info.is_ret = 1'b1;
      OP_STALL: begin
        info.is_event = 1'b1;
        info.nargs    = CNT_W'(1);
      end
      OP_CHIPSEL: info.is_event = 1'b1;
      OP_DRAW: begin
        info.is_event = 1'b1;
        info.nargs    = CNT_W'(3);
      end
      OP_DRAWIDX: begin
        info.is_event = 1'b1;
        info.nargs    = CNT_W'(4);
      end
      OP_DRAW2D: begin
        info.is_event = 1'b1;
        info.nargs    = {{(CNT_W-RECT_W-1){1'b0}}, hdr[RECT_LSB +: RECT_W], 1'b1};
      end
      default: info.legal = 1'b0;
    endcase
    // header plus nargs is odd exactly when nargs is even
    info.pad = ~info.nargs[0];
  end

endmodule

// File: rtl/cmdp_fx2fp.sv
module cmdp_fx2fp
  import cmdp_pkg::*;
(
  input  logic [WORD_W-1:0] fx,
  output logic [WORD_W-1:0] fp
);

  localparam int LEAD_W = $clog2(WORD_W);

  logic              neg;
  logic [WORD_W-1:0] mag;
  logic [WORD_W-1:0] norm;
  logic [LEAD_W-1:0] lead;
  logic [EXP_W-1:0]  expo;

  always_comb begin
    neg  = fx[WORD_W-1];
    mag  = neg ? (~fx + 1'b1) : fx;
    lead = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (mag[i]) lead = LEAD_W'(i);
    end
    norm = mag << (LEAD_W'(WORD_W-1) - lead);
    expo = EXP_W'(lead) + EXP_W'(EXP_BIAS - FRAC_W);
    if (mag == '0) fp = '0;
    else           fp = {neg, expo, norm[WORD_W-2 -: MANT_W]};
  end

endmodule

// File: rtl/cmdp_top.sv
module cmdp_top
  import cmdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_data,
  output logic                in_ready,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic                ev_valid,
  input  logic                ev_ready,
  output logic [OP_W-1:0]     ev_op,
  output logic [WORD_W-1:0]   ev_data,
  output logic                ev_first,
  output logic                ev_last,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [KIND_W-1:0]   rd_kind,
  output logic [WORD_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]    rd_bytes,
  output logic                ended,
  output logic                err
);

  pstate_e           state;
  hdr_info_t         info;
  logic [WORD_W-1:0] conv;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] waddr;
  logic              fixp;
  logic              pad_pend;
  logic              wait_pend;
  logic [CNT_W-1:0]  wait_cnt;
  redir_e            jkind;
  logic [CNT_W-1:0]  jbytes;
  logic [OP_W-1:0]   cur_op;
  logic              wr_free, ev_free, rd_free, acc;

  cmdp_hdr_dec u_dec (.hdr(in_data), .info(info));
  cmdp_fx2fp   u_cvt (.fx(in_data), .fp(conv));

  assign wr_free = !wr_valid || wr_ready;
  assign ev_free = !ev_valid || ev_ready;
  assign rd_free = !rd_valid || rd_ready;

  always_comb begin
    case (state)
      ST_HDR:   in_ready = ev_free && rd_free;
      ST_DATA:  in_ready = wr_free;
      ST_EVARG: in_ready = ev_free;
      ST_JARG:  in_ready = rd_free;
      ST_PAD:   in_ready = 1'b1;
      default:  in_ready = 1'b0;
    endcase
  end

  assign acc   = in_valid && in_ready;
  assign ended = (state == ST_END);
  assign err   = (state == ST_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HDR;
      remain    <= '0;
      waddr     <= '0;
      fixp      <= 1'b0;
      pad_pend  <= 1'b0;
      wait_pend <= 1'b0;
      wait_cnt  <= '0;
      jkind     <= RD_NONE;
      jbytes    <= '0;
      cur_op    <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ev_valid  <= 1'b0;
      ev_op     <= '0;
      ev_data   <= '0;
      ev_first  <= 1'b0;
      ev_last   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_kind   <= '0;
      rd_addr   <= '0;
      rd_bytes  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (ev_valid && ev_ready) ev_valid <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;

      case (state)
        ST_HDR: if (acc) begin
          if (!info.legal) begin
            state <= ST_ERR;
          end else begin
            pad_pend  <= info.pad;
            remain    <= info.nargs;
            wait_pend <= 1'b0;
            cur_op    <= info.op;
            if (info.is_state) begin
              waddr <= in_data[ADDR_W-1:0];
              fixp  <= in_data[FIXP_BIT];
              state <= (info.nargs == '0) ? ST_PAD : ST_DATA;
            end else if (info.is_end) begin
              state <= ST_END;
            end else if (info.is_wait) begin
              wait_pend <= 1'b1;
              wait_cnt  <= in_data[CNT_W-1:0];
              state     <= ST_PAD;
            end else if (info.is_jump) begin
              jkind  <= (info.op == OP_CALL) ? RD_CALL : RD_LINK;
              jbytes <= in_data[CNT_W-1:0];
              state  <= ST_JARG;
            end else if (info.is_ret) begin
              rd_valid <= 1'b1;
              rd_kind  <= RD_RET;
              rd_addr  <= '0;
              rd_bytes <= '0;
              state    <= ST_PAD;
            end else if (info.is_event) begin
              ev_valid <= 1'b1;
              ev_op    <= info.op;
              ev_data  <= in_data;
              ev_first <= 1'b1;
              ev_last  <= (info.nargs == '0);
              state    <= (info.nargs == '0) ? ST_PAD : ST_EVARG;
            end else begin
              state <= ST_PAD;
            end
          end
        end

        ST_DATA: if (acc) begin
          wr_valid <= 1'b1;
          wr_addr  <= waddr;
          wr_data  <= fixp ? conv : in_data;
          waddr    <= waddr + 1'b1;
          remain   <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= pad_pend ? ST_PAD : ST_HDR;
        end

        ST_EVARG: if (acc) begin
          ev_valid <= 1'b1;
          ev_op    <= cur_op;
          ev_data  <= in_data;
          ev_first <= 1'b0;
          ev_last  <= (remain == CNT_W'(1));
          remain   <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= pad_pend ? ST_PAD : ST_HDR;
        end

        ST_JARG: if (acc) begin
          rd_valid <= 1'b1;
          rd_kind  <= jkind;
          rd_addr  <= in_data;
          rd_bytes <= jbytes;
          state    <= ST_HDR;
        end

        ST_PAD: if (acc) begin
          wait_pend <= 1'b0;
          state     <= (wait_pend && wait_cnt != '0) ? ST_WAIT : ST_HDR;
        end

        ST_WAIT: begin
          wait_cnt <= wait_cnt - 1'b1;
          if (wait_cnt == CNT_W'(1)) state <= ST_HDR;
        end

        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/cmdp_chk.sv
module cmdp_chk
  import cmdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [OP_W-1:0]   ev_op,
  input logic [WORD_W-1:0] ev_data,
  input logic              ev_first,
  input logic              ev_last,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [KIND_W-1:0] rd_kind,
  input logic [WORD_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  rd_bytes,
  input logic              ended,
  input logic              err
);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R9
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_data) && $stable(ev_op)
                              && $stable(ev_first) && $stable(ev_last));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_kind) && $stable(rd_addr)
                              && $stable(rd_bytes));

  // R1
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !in_ready);

  // R8
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ended |=> ended && !in_ready && !err);

  // R6
  rd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_kind != 2'd0);

  // R6
  ret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_kind == 2'd3 |-> rd_addr == '0 && rd_bytes == '0);

endmodule

bind cmdp_top cmdp_chk u_chk (.*);

// File: tb/cmdp_top_test.sv
module cmdp_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        ev_valid, ev_ready;
  logic [4:0]  ev_op;
  logic [31:0] ev_data;
  logic        ev_first, ev_last;
  logic        rd_valid, rd_ready;
  logic [1:0]  rd_kind;
  logic [31:0] rd_addr;
  logic [15:0] rd_bytes;
  logic        ended, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdp_top uut (.*);

  logic [31:0] in_q[$];
  logic [48:0] exp_wr[$];   // {tag_fixp, addr, data}
  logic [38:0] exp_ev[$];   // {op, first, last, data}
  logic [49:0] exp_rd[$];   // {kind, addr, bytes}
  int          fire_cyc[$];
  int          in_pos, cyc, errors, checks, rdy_pct;
  bit          always_v, wd_hit;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_fp(input logic [31:0] x);
    real         r;
    logic [63:0] b;
    logic [10:0] e;
    if (x == 32'd0) return 32'd0;
    r = $itor($signed(x)) / 65536.0;
    b = $realtobits(r);
    e = b[62:52];
    return {b[63], 8'(e - 11'd1023 + 11'd127), b[51:29]};
  endfunction

  task automatic step();
    logic [48:0] w;
    logic [38:0] v;
    logic [49:0] q;
    @(negedge clk);
    if (in_pos < in_q.size()) begin
      in_valid = always_v ? 1'b1 : ($urandom % 4 != 0);
      in_data  = in_q[in_pos];
    end else begin
      in_valid = 1'b0;
      in_data  = $urandom;
    end
    wr_ready = ($urandom % 100) < rdy_pct;
    ev_ready = ($urandom % 100) < rdy_pct;
    rd_ready = ($urandom % 100) < rdy_pct;
    #1;
    if (in_valid && in_ready) begin
      fire_cyc.push_back(cyc);
      in_pos++;
    end
    if (wr_valid && wr_ready) begin
      if (exp_wr.size() == 0) chk(0, "R4 unexpected write", {16'd0, wr_addr, wr_data}, 0);
      else begin
        w = exp_wr.pop_front();
        chk({wr_addr, wr_data} == w[47:0], w[48] ? "R3 converted write" : "R2 state write",
            {16'd0, wr_addr, wr_data}, {16'd0, w[47:0]});
      end
    end
    if (ev_valid && ev_ready) begin
      if (exp_ev.size() == 0) chk(0, "R7 unexpected event", {25'd0, ev_op, ev_first, ev_last, ev_data}, 0);
      else begin
        v = exp_ev.pop_front();
        chk({ev_op, ev_first, ev_last, ev_data} == v, "R7 event beat",
            {25'd0, ev_op, ev_first, ev_last, ev_data}, {25'd0, v});
      end
    end
    if (rd_valid && rd_ready) begin
      if (exp_rd.size() == 0) chk(0, "R6 unexpected redirect", {14'd0, rd_kind, rd_addr, rd_bytes}, 0);
      else begin
        q = exp_rd.pop_front();
        chk({rd_kind, rd_addr, rd_bytes} == q, "R6 redirect beat",
            {14'd0, rd_kind, rd_addr, rd_bytes}, {14'd0, q});
      end
    end
    cyc++;
    if (cyc > WD_LIMIT && !wd_hit) begin
      wd_hit = 1'b1;
      chk(0, "R9 watchdog cycles", 64'(cyc), 64'(WD_LIMIT));
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    wr_ready = 1'b0;
    ev_ready = 1'b0;
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    in_q.delete(); exp_wr.delete(); exp_ev.delete(); exp_rd.delete(); fire_cyc.delete();
    in_pos = 0;
    rst_n  = 1'b1;
    #1;
    // R10
    chk(in_ready && !wr_valid && !ev_valid && !rd_valid && !ended && !err,
        "R10 reset state", {in_ready, wr_valid, ev_valid, rd_valid, ended, err}, 6'b100000);
  endtask

  task automatic run_drain();
    while ((in_pos < in_q.size() || exp_wr.size() != 0 || exp_ev.size() != 0 ||
            exp_rd.size() != 0) && !wd_hit) step();
    repeat (4) step();
  endtask

  task automatic push_pad_if(input bit need);
    if (need) in_q.push_back($urandom);
  endtask

  task automatic gen_cmd();
    int          k, n, na;
    logic [31:0] h, d;
    logic [15:0] base;
    bit          fx;
    logic [31:0] spec[6];
    spec = '{32'h0, 32'h8000_0000, 32'hFFFF_0000, 32'h0001_0000, 32'h7FFF_FFFF, 32'h1};
    k = $urandom % 11;
    case (k)
      0, 1: begin
        n = $urandom % 6; fx = $urandom % 2; base = 16'($urandom);
        h = {5'd1, fx, 10'(n), base};
        in_q.push_back(h);
        for (int i = 0; i < n; i++) begin
          d = ($urandom % 2) ? spec[$urandom % 6] : $urandom;
          in_q.push_back(d);
          exp_wr.push_back({fx, 16'(base + 16'(i)), fx ? ref_fp(d) : d});
        end
        push_pad_if(n % 2 == 0);
      end
      2: begin in_q.push_back({5'd3, 27'($urandom)}); push_pad_if(1); end
      3, 4: begin
        h = {(k == 3) ? 5'd8 : 5'd10, 27'($urandom)}; d = $urandom;
        in_q.push_back(h); in_q.push_back(d);
        exp_rd.push_back({(k == 3) ? 2'd1 : 2'd2, d, h[15:0]});
      end
      5: begin
        in_q.push_back({5'd11, 27'($urandom)}); push_pad_if(1);
        exp_rd.push_back({2'd3, 32'd0, 16'd0});
      end
      6, 7, 8: begin
        h = {(k == 6) ? 5'd5 : (k == 7) ? 5'd6 : 5'd9, 27'($urandom)};
        na = (k == 6) ? 3 : (k == 7) ? 4 : 1;
        in_q.push_back(h); exp_ev.push_back({h[31:27], 1'b1, 1'b0, h});
        for (int i = 0; i < na; i++) begin
          d = $urandom; in_q.push_back(d);
          exp_ev.push_back({h[31:27], 1'b0, i == na - 1, d});
        end
        push_pad_if(na % 2 == 0);
      end
      9: begin
        if ($urandom % 2) begin
          h = {5'd13, 27'($urandom)};
          in_q.push_back(h); exp_ev.push_back({5'd13, 1'b1, 1'b1, h}); push_pad_if(1);
        end else begin
          n = $urandom % 3;
          h = {5'd4, 11'($urandom), 8'(n), 8'($urandom)};
          na = 1 + 2 * n;
          in_q.push_back(h); exp_ev.push_back({5'd4, 1'b1, 1'b0, h});
          for (int i = 0; i < na; i++) begin
            d = $urandom; in_q.push_back(d);
            exp_ev.push_back({5'd4, 1'b0, i == na - 1, d});
          end
        end
      end
      default: begin
        in_q.push_back({5'd7, 11'($urandom), 16'($urandom % 4)}); push_pad_if(1);
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'd20240611));
    errors = 0; checks = 0; cyc = 0; wd_hit = 0;
    always_v = 1'b1; rdy_pct = 100;

    // R5: wait timing, counts 5 and 0
    do_reset();
    in_q = '{{5'd7, 11'd0, 16'd5}, 32'hFFFF_FFFF, {5'd3, 27'd0}, 32'd0,
             {5'd7, 11'd0, 16'd0}, 32'h0, {5'd3, 27'd0}, 32'h0};
    run_drain();
    chk(fire_cyc.size() == 8, "R5 words taken", 64'(fire_cyc.size()), 64'd8);
    if (fire_cyc.size() == 8) begin
      chk(fire_cyc[2] - fire_cyc[1] == 6, "R5 wait 5 gap", 64'(fire_cyc[2] - fire_cyc[1]), 64'd6);
      chk(fire_cyc[6] - fire_cyc[5] == 1, "R5 wait 0 gap", 64'(fire_cyc[6] - fire_cyc[5]), 64'd1);
    end
    chk(!err, "R4 pad 0xFFFFFFFF skipped", 64'(err), 64'd0);

    // R3: directed conversion values, stalled sink
    do_reset();
    rdy_pct = 30;
    in_q = '{{5'd1, 1'b1, 10'd4, 16'hFFFE}, 32'h0, 32'h8000_0000, 32'hFFFF_0000, 32'h0001_8000, 32'h0};
    exp_wr.push_back({1'b1, 16'hFFFE, 32'h0000_0000});
    exp_wr.push_back({1'b1, 16'hFFFF, 32'hC700_0000});
    exp_wr.push_back({1'b1, 16'h0000, 32'hBF80_0000});
    exp_wr.push_back({1'b1, 16'h0001, 32'h3FC0_0000});
    run_drain();
    chk(exp_wr.size() == 0, "R3 all converted writes seen", 64'(exp_wr.size()), 64'd0);

    // R1: illegal opcodes stick
    do_reset();
    rdy_pct = 100;
    in_q = '{32'h6000_0000, {5'd3, 27'd0}, 32'h0};
    repeat (6) step();
    chk(err && !in_ready, "R1 err after opcode 12", {err, in_ready}, 2'b10);
    chk(in_pos == 1, "R1 no word after illegal", 64'(in_pos), 64'd1);
    do_reset();
    in_q = '{32'h0000_0000, {5'd3, 27'd0}};
    repeat (6) step();
    chk(err && in_pos == 1, "R1 err after opcode 0", {err, 8'(in_pos)}, {1'b1, 8'd1});

    // R8: end parks the parser
    do_reset();
    in_q = '{32'h1000_0000, {5'd3, 27'd0}, 32'h0};
    repeat (6) step();
    chk(ended && !in_ready && !err, "R8 ended", {ended, in_ready, err}, 3'b100);
    chk(in_pos == 1, "R8 no word after end", 64'(in_pos), 64'd1);

    // R2 R4 R6 R7 R9: random command mixes under varying back-pressure
    for (int round = 0; round < 3; round++) begin
      do_reset();
      rdy_pct  = (round == 0) ? 100 : (round == 1) ? 60 : 25;
      always_v = (round == 0);
      for (int c = 0; c < 40; c++) gen_cmd();
      run_drain();
      chk(!err && !ended, "R4 pads never decoded", {err, ended}, 2'b00);
      chk(exp_wr.size() + exp_ev.size() + exp_rd.size() == 0, "R9 no beat lost",
          64'(exp_wr.size() + exp_ev.size() + exp_rd.size()), 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule